// File: doc/BRIEF.md
# Multi-Channel Response Collector

This block gathers response words from a bank of device channels and feeds them into the push port of an inbound mailbox FIFO. Each channel raises an available flag while it holds a word and presents that word on its data bus. On a scan, the collector visits the channels from index 0 upward. It stays on a channel and moves one word per clock while that channel keeps its flag high and the FIFO has room. It then steps to the next index. Each word it takes is acknowledged back to the channel that supplied it.

A scan starts when the trigger input pulses, for example after every register access. A scan also starts when any available flag changes while the collector is idle. Flag changes that happen during a scan, including those the collector causes by taking words, are absorbed by the running scan. Trigger pulses that arrive during a scan are merged into a single follow-up scan. When a scan finishes, the block refreshes its interrupt-pending state from the FIFO occupancy. It also reports a protocol error whenever a channel delivers the reserved invalid word.

Top module: `resp_collector`

## Requirements
- R1: While reset is held low and afterwards until a scan starts, busy, push, acknowledge, interrupt, pending and error outputs are all 0.
- R2: While idle, a high trigger or any change of the available vector against the previous cycle makes busy high in the next cycle.
- R3: Every scan starts at channel 0 and visits channels in ascending order. A channel keeps being served, without advancing the index, for as long as it is served.
- R4: A channel is served in a scan cycle when its available flag is high and the FIFO is not full. In that cycle push is 1, only that channel's acknowledge bit is 1, and the FIFO data equals that channel's word. Otherwise push, acknowledge and FIFO data are 0.
- R5: When the FIFO is full, no word is pushed. The scan moves past the current channel, and words left behind stay with the channel until a later scan.
- R6: During a scan, the fetch address equals the current channel index shifted left by ADDR_SHIFT (4). It is 0 when idle.
- R7: Available-flag changes during a scan do not start another scan after it.
- R8: Any number of trigger pulses during a scan cause exactly one extra scan, which begins right after the closing cycle.
- R9: Each scan ends with one closing cycle, after which pending equals "FIFO not empty" as sampled in that cycle. The interrupt output equals pending AND the interrupt enable.
- R10: A pushed word equal to INVALID_WORD (all ones) raises the error output for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Scan request pulse |
| chan_avail_i | input | NUM_CH | Per-channel word-available flags |
| chan_data_i | input | NUM_CH*DATA_W | Per-channel words, channel c at bits c*DATA_W upward |
| chan_ack_o | output | NUM_CH | Per-channel word-taken strobe |
| fetch_addr_o | output | 4+ADDR_SHIFT | Address of the channel being served |
| fifo_push_o | output | 1 | FIFO push strobe |
| fifo_data_o | output | DATA_W | FIFO push word |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| irq_en_i | input | 1 | Interrupt enable |
| irq_pend_o | output | 1 | Interrupt pending (FIFO holds data) |
| irq_o | output | 1 | Interrupt request |
| proto_err_o | output | 1 | Invalid-word strobe |
| busy_o | output | 1 | Scan in progress |

## Verification
Push, acknowledge, FIFO data and fetch address are combinational in a scan cycle and are due in the same cycle as the channel state that produces them. Busy follows a trigger or flag change by one clock. Pending and the interrupt change one clock after the closing cycle, and the error strobe follows the offending push by one clock. The bench drives inputs at the falling edge and compares every output 1 ns later against a behavioural model, which advances on the rising edge. Every one of these latencies is therefore checked in the exact cycle it is due. Scenario checks on busy-cycle counts and leftover channel words cover the follow-up scan and the absorbed flag changes.

// File: rtl/rc_pkg.sv
// Shared types for the response collector.
package rc_pkg;
    typedef enum logic [1:0] {
        RC_IDLE = 2'd0,
        RC_SCAN = 2'd1,
        RC_DONE = 2'd2
    } rc_state_e;
endpackage

// File: rtl/rc_chan_mux.sv
// Channel selector: picks the indexed channel's flag and word and decodes
// the acknowledge strobe. Assumes idx < NUM_CH while serve_en can be high.
module rc_chan_mux #(
    parameter int NUM_CH = 9,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     scan_active,
    input  logic                     fifo_full,
    input  logic [NUM_CH-1:0]        avail,
    input  logic [NUM_CH*DATA_W-1:0] data,
    output logic                     serve,
    output logic [DATA_W-1:0]        sel_data,
    output logic [NUM_CH-1:0]        ack
);
    logic [NUM_CH-1:0] hit;

    // Per-channel index match and acknowledge.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c] = (idx == IDX_W'(c));
        assign ack[c] = hit[c] & avail[c] & scan_active & ~fifo_full;
    end

    assign serve = |ack;

    // Word of the served channel, zero when nothing is served.
    always_comb begin
        sel_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ack[c]) sel_data = data[c*DATA_W +: DATA_W];
        end
    end

    assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
endmodule

// File: rtl/rc_scan_fsm.sv
// Scan sequencer: starts a scan on trigger or flag change, walks the
// channel index upward, stays while serving, closes with one DONE cycle,
// and replays one scan for triggers seen mid-scan.
module rc_scan_fsm
    import rc_pkg::*;
#(
    parameter int NUM_CH = 9,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [NUM_CH-1:0] avail,
    input  logic              serve,
    output rc_state_e         state,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    rc_state_e         st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [NUM_CH-1:0] prev_q;
    logic              rerun_q;

    // Track flags every cycle so changes during a scan are absorbed.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= avail;
    end

    // State, channel index and latched re-scan request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RC_IDLE;
            idx_q   <= '0;
            rerun_q <= 1'b0;
        end else begin
            case (st_q)
                RC_IDLE: begin
                    if (trig || (avail != prev_q)) begin
                        st_q  <= RC_SCAN;
                        idx_q <= '0;
                    end
                end
                RC_SCAN: begin
                    if (trig) rerun_q <= 1'b1;
                    if (!serve) begin
                        if (idx_q == LAST) st_q  <= RC_DONE;
                        else               idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    idx_q   <= '0;
                    rerun_q <= 1'b0;
                    st_q    <= (rerun_q || trig) ? RC_SCAN : RC_IDLE;
                end
            endcase
        end
    end

    assign state = st_q;
    assign idx   = idx_q;

    assert_scan_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != RC_SCAN) |=> (st_q != RC_SCAN || idx_q == '0));
    assert_stay_while_serving_R3: assert property (@(posedge clk) disable iff (!rst_n)
        serve |=> (st_q == RC_SCAN && $stable(idx_q)));
endmodule

// File: rtl/rc_irq_state.sv
// Interrupt and error state: refreshes pending at the closing cycle of a
// scan and flags a pushed invalid word one cycle later.
module rc_irq_state #(
    parameter int              DATA_W       = 32,
    parameter logic [DATA_W-1:0] INVALID_WORD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_close,
    input  logic              fifo_empty,
    input  logic              irq_en,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              pend,
    output logic              irq,
    output logic              err
);
    logic pend_q;
    logic err_q;

    // Pending follows FIFO occupancy, sampled at scan close.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (scan_close) pend_q <= ~fifo_empty;
    end

    // One-cycle strobe for an invalid word pushed.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= push && (push_data == INVALID_WORD);
    end

    assign pend = pend_q;
    assign irq  = pend_q & irq_en;
    assign err  = err_q;

    assert_pend_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_close |=> (pend_q == !$past(fifo_empty)));
endmodule

// File: rtl/resp_collector.sv
// Response collector top: moves words from NUM_CH channels into an inbound
// FIFO, one per clock, in ascending channel order. Assumes NUM_CH <= 16 and
// that a channel updates its flag and word the cycle after an acknowledge.
module resp_collector
    import rc_pkg::*;
#(
    parameter int                NUM_CH       = 9,
    parameter int                DATA_W       = 32,
    parameter int                ADDR_SHIFT   = 4,
    parameter logic [DATA_W-1:0] INVALID_WORD = '1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig_i,
    input  logic [NUM_CH-1:0]          chan_avail_i,
    input  logic [NUM_CH*DATA_W-1:0]   chan_data_i,
    output logic [NUM_CH-1:0]          chan_ack_o,
    output logic [4+ADDR_SHIFT-1:0]    fetch_addr_o,
    output logic                       fifo_push_o,
    output logic [DATA_W-1:0]          fifo_data_o,
    input  logic                       fifo_full_i,
    input  logic                       fifo_empty_i,
    input  logic                       irq_en_i,
    output logic                       irq_pend_o,
    output logic                       irq_o,
    output logic                       proto_err_o,
    output logic                       busy_o
);
    localparam int IDX_W  = 4;
    localparam int ADDR_W = IDX_W + ADDR_SHIFT;

    rc_state_e        state;
    logic [IDX_W-1:0] idx;
    logic             serve;

    rc_scan_fsm #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_i),
        .avail (chan_avail_i),
        .serve (serve),
        .state (state),
        .idx   (idx)
    );

    rc_chan_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (idx),
        .scan_active (state == RC_SCAN),
        .fifo_full   (fifo_full_i),
        .avail       (chan_avail_i),
        .data        (chan_data_i),
        .serve       (serve),
        .sel_data    (fifo_data_o),
        .ack         (chan_ack_o)
    );

    rc_irq_state #(.DATA_W(DATA_W), .INVALID_WORD(INVALID_WORD)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_close (state == RC_DONE),
        .fifo_empty (fifo_empty_i),
        .irq_en     (irq_en_i),
        .push       (serve),
        .push_data  (fifo_data_o),
        .pend       (irq_pend_o),
        .irq        (irq_o),
        .err        (proto_err_o)
    );

    assign fifo_push_o  = serve;
    assign busy_o       = (state != RC_IDLE);
    assign fetch_addr_o = (state == RC_SCAN) ? (ADDR_W'(idx) << ADDR_SHIFT) : '0;

    assert_no_push_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push_o |-> !fifo_full_i);
    assert_err_after_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(fifo_push_o));
endmodule

// File: tb/sim_resp_collector.sv
module sim_resp_collector;
    localparam int N     = 9;
    localparam int W     = 32;
    localparam int SH    = 4;
    localparam int DEPTH = 4;
    localparam logic [W-1:0] INV = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [N-1:0] avail = '0;
    logic [N*W-1:0] cdata = '0;
    logic full = 1'b0, empty = 1'b1, irq_en = 1'b0;
    logic [N-1:0] ack;
    logic [4+SH-1:0] addr;
    logic push, pend, irq, err, busy;
    logic [W-1:0] fdata;

    always #5 clk = ~clk;

    resp_collector #(.NUM_CH(N), .DATA_W(W), .ADDR_SHIFT(SH)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .chan_avail_i(avail),
        .chan_data_i(cdata), .chan_ack_o(ack), .fetch_addr_o(addr),
        .fifo_push_o(push), .fifo_data_o(fdata), .fifo_full_i(full),
        .fifo_empty_i(empty), .irq_en_i(irq_en), .irq_pend_o(pend),
        .irq_o(irq), .proto_err_o(err), .busy_o(busy)
    );

    int n_tests = 0, n_fail = 0;
    logic [W-1:0] chq [N][$];
    int fcnt = 0;
    logic fpop = 1'b0;
    int st_m = 0, idx_m = 0;
    bit rq_m = 0, pend_m = 0, err_m = 0;
    logic [N-1:0] prev_m = '0;
    int busy_cnt = 0, push_cnt = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at falling edge, compare, advance model at rising edge.
    task automatic cyc();
        bit srv;
        logic [W-1:0] w;
        for (int c = 0; c < N; c++) begin
            avail[c] = chq[c].size() > 0;
            cdata[c*W +: W] = (chq[c].size() > 0) ? chq[c][0] : '0;
        end
        full = fcnt >= DEPTH;
        empty = fcnt == 0;
        #1;
        srv = (st_m == 1) && avail[idx_m] && (fcnt < DEPTH);
        w = srv ? chq[idx_m][0] : '0;
        if (rst_n) begin
            chk("R4 push", push, srv);
            chk("R4 ack", ack, srv ? (N'(1) << idx_m) : '0);
            chk("R3 data", fdata, w);
            chk("R6 addr", addr, (st_m == 1) ? (idx_m << SH) : 0);
            chk("R2 busy", busy, st_m != 0);
            chk("R9 pend", pend, pend_m);
            chk("R9 irq", irq, pend_m & irq_en);
            chk("R10 err", err, err_m);
        end
        if (busy) busy_cnt++;
        if (push) push_cnt++;
        @(posedge clk);
        if (!rst_n) begin
            st_m = 0; idx_m = 0; rq_m = 0; pend_m = 0; err_m = 0; prev_m = '0;
        end else begin
            err_m = srv && (w == INV);
            case (st_m)
                0: if (trig || avail != prev_m) begin st_m = 1; idx_m = 0; end
                1: begin
                    if (trig) rq_m = 1;
                    if (!srv) begin
                        if (idx_m == N - 1) st_m = 2; else idx_m++;
                    end
                end
                default: begin
                    pend_m = (fcnt != 0);
                    st_m = (rq_m || trig) ? 1 : 0;
                    idx_m = 0; rq_m = 0;
                end
            endcase
            prev_m = avail;
        end
        fcnt = fcnt + (srv ? 1 : 0) - ((fpop && fcnt > 0) ? 1 : 0);
        if (srv) void'(chq[idx_m].pop_front());
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic drain();
        fpop = 1'b1;
        while (fcnt > 0) cyc();
        fpop = 1'b0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        run(3);
        // R1: outputs quiet in and right after reset
        chk("R1 busy", busy, 0); chk("R1 push", push, 0); chk("R1 ack", ack, 0);
        chk("R1 irq", irq, 0); chk("R1 pend", pend, 0); chk("R1 err", err, 0);
        rst_n = 1'b1;
        run(3);
        chk("R1 idle after reset", busy, 0);

        // Flag change starts scan; ch0 then ch2 in order (R3, R4)
        irq_en = 1'b1;
        chq[2].push_back(32'h2222_0001); chq[2].push_back(32'h2222_0002);
        chq[0].push_back(32'h0000_00A0);
        busy_cnt = 0; push_cnt = 0;
        run(20);
        chk("R3 words moved", push_cnt, 3);
        chk("R7 single scan", busy_cnt, 3 + N + 1);
        chk("R9 irq after scan", irq, 1);
        drain();
        trig = 1'b1; cyc(); trig = 1'b0;
        run(14);
        chk("R9 pend cleared", pend, 0);

        // FIFO full: channel left with words (R5)
        for (int k = 0; k < 6; k++) chq[1].push_back(32'h1100_0000 + k);
        push_cnt = 0;
        run(20);
        chk("R5 pushes limited", push_cnt, DEPTH);
        chk("R5 words kept", chq[1].size(), 2);
        drain();
        trig = 1'b1; cyc(); trig = 1'b0;
        run(16);
        chk("R5 leftovers moved", chq[1].size(), 0);
        drain();

        // Triggers mid-scan give exactly one extra scan (R8)
        for (int k = 0; k < 3; k++) chq[3].push_back(32'h3300_0000 + k);
        busy_cnt = 0;
        cyc(); cyc();
        trig = 1'b1; cyc(); cyc(); trig = 1'b0;
        run(40);
        chk("R8 one extra scan", busy_cnt, (3 + N + 1) + (N + 1));
        drain();

        // Invalid word raises error (R10)
        chq[5].push_back(INV);
        run(16);
        drain();

        // Trigger in idle with no data (R2)
        busy_cnt = 0;
        trig = 1'b1; cyc(); trig = 1'b0;
        run(15);
        chk("R2 empty scan length", busy_cnt, N + 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule